// File: doc/BRIEF.md
# Unaligned Byte Stream to Flash Word Packer

This block takes a byte stream that begins at any byte address and runs for any length, and turns it into a series of aligned four-byte program requests for a flash array whose cells can only be cleared from one to zero. A request starts with a single `start` pulse that loads the byte address and the length. The bytes then arrive one per transfer on a valid/ready input. Each finished word leaves on a valid/ready output as a word-aligned address and a 32-bit data value.

Byte lanes that the request does not cover are set to all-ones. Programming all-ones leaves a flash cell as it was, so the bytes next to the request keep their stored contents and no read-modify-write is needed. The downstream programmer can flag a failure on the word it is accepting. When it does, packing stops at once. When the request ends, normally or through a failure, a one-cycle `done` pulse reports the outcome together with the number of real data bytes that were programmed. Padding lanes are never counted.

Top module: `bpk_packer`

## Requirements
- R1: Every output word is four bytes wide and its address is a multiple of four. Byte lane 0 (bits 7:0) holds the lowest byte address of the word, and lane 3 (bits 31:24) holds the highest.
- R2: When the start address is not a multiple of four, the first word goes to the start address rounded down to a multiple of four. Its lanes below the start offset are 0xFF, and the first input byte lands in lane `start_addr[1:0]`.
- R3: When the whole request fits inside that first word, the lanes above the last data byte are also 0xFF.
- R4: Each word between the first and the last carries four consecutive input bytes unchanged, in order. The address of each word is four above the address of the word before it.
- R5: A final partial word holds the remaining bytes in its low lanes, and its upper lanes are 0xFF.
- R6: On a successful finish, `done` pulses for one cycle with `done_fail` low, and `byte_count` equals the requested length. `byte_count` holds its value until the next request finishes.
- R7: When `prog_fail` is high while a word is accepted, no further words or input bytes are taken. `done` pulses in the next cycle with `done_fail` high, and `byte_count` equals the data bytes in the words accepted before the failing one.
- R8: A zero-length request produces no output word and no input transfer. `done` pulses in the cycle after `start` with `done_fail` low and `byte_count` zero.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_word` hold steady. `in_ready` stays low while a word is waiting.
- R10: A `start` pulse while `busy` is high is ignored. The running request finishes with its own address, length, words and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a new request; taken only when idle |
| start_addr | input | ADDR_W | Byte address of the first data byte |
| req_len | input | LEN_W | Number of data bytes in the request |
| in_valid | input | 1 | Input byte available |
| in_byte | input | 8 | Input data byte |
| in_ready | output | 1 | Packer accepts an input byte |
| out_valid | output | 1 | Program word available |
| out_ready | input | 1 | Downstream accepts the word |
| prog_fail | input | 1 | Downstream flags a failed program on the accepted word |
| out_addr | output | ADDR_W | Word-aligned byte address of the word |
| out_word | output | 32 | Word data, lane 0 at the lowest address |
| done | output | 1 | One-cycle pulse at the end of a request |
| done_fail | output | 1 | The request ended on a program failure |
| byte_count | output | LEN_W | Data bytes programmed by the last request |
| busy | output | 1 | A request is in progress |

## Verification
The bench builds the packer with ADDR_W=8 and LEN_W=5. This keeps the addresses small enough to compute by hand and still reaches the full length range of a short request. Every start offset from 0 to 3 is crossed with every length from 0 to 13, plus the maximum length of 31. That covers empty requests, requests inside one word, requests that straddle one boundary, and requests with several full middle words. Stalls on the input side and on the output side vary with the case, so the hold behaviour is exercised. Failures are injected on the first, middle and last word of a three-word request, and a stray start is sent into a running request.

// File: rtl/bpk_pkg.sv
package bpk_pkg;
  localparam int WORD_BYTES = 4;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam logic [7:0] PAD_BYTE = 8'hFF;

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic [1:0] {
    PK_IDLE = 2'd0,
    PK_FILL = 2'd1,
    PK_EMIT = 2'd2
  } pk_state_e;

  // A word is closed by its top lane or by the final byte of the request.
  function automatic logic word_closes(lane_t lane, logic final_byte);
    return (lane == lane_t'(WORD_BYTES - 1)) || final_byte;
  endfunction

  // Data bytes that the words accepted so far carried, plus the current word.
  function automatic int unsigned add_bytes(int unsigned total, int unsigned in_word);
    return total + in_word;
  endfunction
endpackage

// File: rtl/bpk_lane_buf.sv
module bpk_lane_buf
  import bpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr_en,
  input  lane_t             wr_lane,
  input  logic [7:0]        wr_byte,
  output logic [WORD_W-1:0] word
);
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= PAD_BYTE;
      else if (wr_en && wr_lane == lane_t'(g))
        lane_q <= wr_byte;
      else if (clear)
        lane_q <= PAD_BYTE;
    end
    assign word[8*g +: 8] = lane_q;
  end
endmodule

// File: rtl/bpk_ctrl.sv
module bpk_ctrl
  import bpk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              prog_fail,
  output logic [ADDR_W-1:0] out_addr,
  output logic              done,
  output logic              done_fail,
  output logic [LEN_W-1:0]  byte_count,
  output logic              busy,
  output logic              buf_clear,
  output logic              buf_wr,
  output lane_t             buf_lane
);
  localparam int WB_W = LANE_W + 1;

  pk_state_e         state_q;
  logic [LEN_W-1:0]  remain_q, total_q, len_q, count_q;
  logic [WB_W-1:0]   wbytes_q;
  logic [ADDR_W-1:0] waddr_q;
  lane_t             lane_q;
  logic              done_q, fail_q;

  // Named events for the assertions and the buffer.
  logic take_start, take_byte, word_acc, word_bad, last_byte, closing;
  logic [LEN_W-1:0] total_next;

  assign take_start = (state_q == PK_IDLE) && start;
  assign take_byte  = (state_q == PK_FILL) && in_valid;
  assign word_acc   = (state_q == PK_EMIT) && out_ready;
  assign word_bad   = word_acc && prog_fail;
  assign last_byte  = (remain_q == LEN_W'(1));
  assign closing    = take_byte && word_closes(lane_q, last_byte);
  assign total_next = LEN_W'(add_bytes(int'(total_q), int'(wbytes_q)));

  assign in_ready   = (state_q == PK_FILL);
  assign out_valid  = (state_q == PK_EMIT);
  assign out_addr   = waddr_q;
  assign busy       = (state_q != PK_IDLE);
  assign done       = done_q;
  assign done_fail  = fail_q;
  assign byte_count = count_q;
  assign buf_clear  = take_start || word_acc;
  assign buf_wr     = take_byte;
  assign buf_lane   = lane_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PK_IDLE;
      remain_q <= '0;
      total_q  <= '0;
      len_q    <= '0;
      count_q  <= '0;
      wbytes_q <= '0;
      waddr_q  <= '0;
      lane_q   <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        PK_IDLE: if (start) begin
          len_q    <= req_len;
          remain_q <= req_len;
          total_q  <= '0;
          wbytes_q <= '0;
          waddr_q  <= {start_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
          lane_q   <= start_addr[LANE_W-1:0];
          if (req_len == '0) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b0;
            count_q <= '0;
          end else begin
            state_q <= PK_FILL;
          end
        end
        PK_FILL: if (in_valid) begin
          remain_q <= remain_q - LEN_W'(1);
          wbytes_q <= wbytes_q + WB_W'(1);
          if (closing) state_q <= PK_EMIT;
          else         lane_q  <= lane_q + lane_t'(1);
        end
        PK_EMIT: if (out_ready) begin
          if (prog_fail) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
            count_q <= total_q;
            state_q <= PK_IDLE;
          end else if (remain_q == '0) begin
            done_q  <= 1'b1;
            fail_q  <= 1'b0;
            count_q <= total_next;
            state_q <= PK_IDLE;
          end else begin
            total_q  <= total_next;
            waddr_q  <= waddr_q + ADDR_W'(WORD_BYTES);
            lane_q   <= '0;
            wbytes_q <= '0;
            state_q  <= PK_FILL;
          end
        end
        default: state_q <= PK_IDLE;
      endcase
    end
  end

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[LANE_W-1:0] == '0)); // R1
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr))); // R9
  AST_NO_INPUT_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (byte_count <= len_q)); // R6
  AST_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_fail) |-> (byte_count == len_q)); // R6
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (take_start && req_len == '0) |=> (done && !done_fail && byte_count == '0 && !busy)); // R8
  AST_FAIL_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |=> (done && done_fail && !busy && !in_ready)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(len_q)); // R10
endmodule

// File: rtl/bpk_packer.sv
module bpk_packer
  import bpk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              out_valid,
  input  logic              out_ready,
  input  logic              prog_fail,
  output logic [ADDR_W-1:0] out_addr,
  output logic [31:0]       out_word,
  output logic              done,
  output logic              done_fail,
  output logic [LEN_W-1:0]  byte_count,
  output logic              busy
);
  logic  buf_clear, buf_wr;
  lane_t buf_lane;
  logic [WORD_W-1:0] word;

  bpk_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .req_len    (req_len),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .prog_fail  (prog_fail),
    .out_addr   (out_addr),
    .done       (done),
    .done_fail  (done_fail),
    .byte_count (byte_count),
    .busy       (busy),
    .buf_clear  (buf_clear),
    .buf_wr     (buf_wr),
    .buf_lane   (buf_lane)
  );

  bpk_lane_buf u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (buf_clear),
    .wr_en   (buf_wr),
    .wr_lane (buf_lane),
    .wr_byte (in_byte),
    .word    (word)
  );

  assign out_word = word;

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_word)); // R9
  AST_BYTE_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> in_ready); // R9
endmodule

// File: tb/bpk_packer_test.sv
`timescale 1ns/1ps
module bpk_packer_test;
  localparam int AW = 8;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, out_valid, done, done_fail, busy;
  logic out_ready = 1'b0;
  logic prog_fail = 1'b0;
  logic [AW-1:0] out_addr;
  logic [31:0] out_word;
  logic [LW-1:0] byte_count;

  int n_run = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bpk_packer #(.ADDR_W(AW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .req_len(req_len), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
    .prog_fail(prog_fail), .out_addr(out_addr), .out_word(out_word),
    .done(done), .done_fail(done_fail), .byte_count(byte_count), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] dat(int off, int len, int i);
    return {1'b0, 7'((i * 7 + off * 13 + len * 3 + 5) % 128)};
  endfunction

  function automatic logic [31:0] exp_word(int off, int len, int k);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) begin
      int p = 4 * k + j - off;
      w[8*j +: 8] = (p >= 0 && p < len) ? dat(off, len, p) : 8'hFF;
    end
    return w;
  endfunction

  // err_word < 0 means no failure; poke sends a stray start while busy (R10).
  task automatic run(input int off, input int len, input int err_word, input bit poke);
    int nwords, bi, wi, mode, exp_cnt, exp_acc;
    bit finished, held, fails;
    logic [31:0] held_word;
    logic [AW-1:0] held_addr, sa, base;
    string tag;
    sa     = AW'(8'h20 + (len % 4) * 16 + off);
    base   = {sa[AW-1:2], 2'b00};
    nwords = (len == 0) ? 0 : (off + len + 3) / 4;
    fails  = (err_word >= 0) && (err_word < nwords);
    if (fails) exp_cnt = (err_word == 0) ? 0 : ((4 * err_word - off < len) ? 4 * err_word - off : len);
    else       exp_cnt = len;
    exp_acc = fails ? err_word + 1 : nwords;
    mode = (off + len) % 3;
    bi = 0; wi = 0; finished = 0; held = 0; held_word = '0; held_addr = '0;
    @(negedge clk);
    start = 1'b1; start_addr = sa; req_len = LW'(len);
    @(negedge clk);
    for (int cyc = 0; cyc < 300; cyc++) begin
      start      = poke && (cyc == 3);
      start_addr = poke ? AW'(0) : sa;
      req_len    = poke ? LW'(3) : LW'(len);
      in_valid   = (bi < len) && !(mode == 1 && cyc % 4 == 2);
      in_byte    = dat(off, len, bi);
      out_ready  = !(mode == 2 && cyc % 3 == 0);
      prog_fail  = (wi == err_word);
      #1;
      if (done) begin
        finished = 1;
        tag = fails ? "R7" : (len == 0 ? "R8" : (poke ? "R10" : "R6"));
        check(done_fail == fails, tag, "done_fail", 32'(done_fail), 32'(fails));
        check(int'(byte_count) == exp_cnt, tag, "byte_count", 32'(byte_count), 32'(exp_cnt));
        check(wi == exp_acc, tag, "words accepted", 32'(wi), 32'(exp_acc));
        break;
      end
      if (held) begin
        check(out_valid && out_word == held_word && out_addr == held_addr, "R9",
              "held word changed", out_word, held_word);
        held = 0;
      end
      if (out_valid && in_ready) check(0, "R9", "in_ready during pending word", 32'(in_ready), 0);
      if (in_valid && in_ready) bi++;
      if (out_valid && out_ready) begin
        if (wi >= nwords) begin
          check(0, "R7", "extra word", 32'(wi), 32'(nwords));
        end else begin
          tag = (nwords == 1) ? "R3" : (wi == 0 ? "R2" : (wi == nwords - 1 ? "R5" : "R4"));
          check(out_addr == base + AW'(4 * wi), "R1", "word address", 32'(out_addr),
                32'(base + AW'(4 * wi)));
          check(out_word == exp_word(off, len, wi), tag, "word data", out_word,
                exp_word(off, len, wi));
        end
        wi++;
      end else if (out_valid) begin
        held = 1; held_word = out_word; held_addr = out_addr;
      end
      @(negedge clk);
    end
    start = 1'b0; in_valid = 1'b0; out_ready = 1'b0; prog_fail = 1'b0;
    if (!finished) check(0, "R6", "no done", 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !in_ready && !done && !busy && byte_count == '0, "R6",
          "reset state", {out_valid, in_ready, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int off = 0; off < 4; off++)
      for (int len = 0; len < 14; len++)
        run(off, len, -1, 0);
    for (int off = 0; off < 4; off++) run(off, 31, -1, 0);
    run(1, 9, 0, 0);  // R7 failure on first word
    run(1, 9, 1, 0);  // R7 failure on middle word
    run(1, 9, 2, 0);  // R7 failure on last word
    run(3, 1, 0, 0);  // R7 single-word failure
    run(2, 10, -1, 1); // R10 stray start while busy
    run(0, 0, -1, 0); // R8 after all the rest
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL R6 watchdog expired: actual %0d expected %0d", cycles, 100000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule